// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Protection

This block is a slave on a two-wire serial bus. It sits in front of a 256-byte register-file array. The block samples the bus lines on its system clock and recognises Start and Stop conditions. It shifts bytes in and out, and it drives the acknowledge bit by pulling the data line low.

A master writes by sending a memory control byte, a word address and any number of data bytes. The data bytes collect in a 16-byte page buffer, which is written to the array only when the master issues a Stop. The master reads by sending a memory control byte with the read bit set. The slave then streams bytes from its address pointer until the master declines to acknowledge one.

A separate control code carries three protection commands for the lower half of the array: set, clear and permanent. An external pin blocks writes to the whole array. The time the array takes to program is modelled as a fixed count of system clocks. The busy output is high during that count.

Top module: `twire_eeprom`

## Requirements
- R1: A Start condition (data falls while the clock is high) restarts control-byte reception at any point of a transfer and discards buffered write data. A Stop condition (data rises while the clock is high) ends the transfer.
- R2: A control byte whose upper nibble is 1010b is acknowledged: the data line is pulled low through the ninth clock, and the pull changes only while the clock is low. A control byte with any other upper nibble that is not an accepted protection command gets no acknowledge.
- R3: A write is the byte 1010xxx0b, then an address byte, then data bytes, then a Stop. Memory changes only at the Stop. The busy output then goes high for exactly PROG_CYCLES clocks.
- R4: Data bytes go to consecutive addresses, and the address wraps within the 16-byte page selected by address bits 7:4. When more than sixteen bytes arrive, each byte replaces the oldest one still buffered at its slot, so the last sixteen are the ones kept.
- R5: After the control byte 1010xxx1b, bytes are sent MSB first starting at the address pointer. Each byte the master acknowledges advances the pointer, wrapping from FFh to 00h. A missing master acknowledge makes the slave release the data line and end the transfer.
- R6: While busy is high, no control byte is acknowledged and the data line is never pulled.
- R7: The command byte 01100010b (set), once it is followed by a Stop, blocks writes to addresses 00h-7Fh. Writes to 80h-FFh still take effect.
- R8: The command byte 01100110b (clear), once it is followed by a Stop, removes the protection that set added.
- R9: The command byte 01100000b (permanent) blocks 00h-7Fh for good. From then on, any protection command gets no acknowledge and changes nothing.
- R10: While wp_i is high at the Stop of a write, no address of the array changes.
- R11: After reset, the data line is released, busy is low, no protection is active and every memory byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| wp_i | input | 1 | Write-protect pin for the whole array, active high |
| sda_pull_o | output | 1 | Enable of the open-drain pull-down on the data line |
| busy_o | output | 1 | High while a programming cycle is running |

## Verification
The properties assume a well-behaved master. Each clock phase lasts at least three system clocks. Data changes only while the clock is low, except for Start and Stop. The master never ends a transfer while the slave is driving the line low. The bench's master keeps to this: it holds each half period for four system clocks and changes its data line at the same clock edge that lowers the clock. It sends Start and Stop only when the line is released, and it feeds the wired-AND of its own drive and the slave's pull back into sda_i.

// File: rtl/twire_eeprom.sv
module twire_eeprom #(
  parameter int          ADDR_W      = 8,
  parameter int          PAGE_W      = 4,
  parameter int          PROG_CYCLES = 200,
  parameter logic [3:0]  MEM_CODE    = 4'b1010,
  parameter logic [3:0]  PROT_CODE   = 4'b0110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [2:0] OP_PERM = 3'b000, OP_SET = 3'b001, OP_CLR = 3'b011;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WR, S_RD, S_PROT} st_t;

  logic scl_q, scl_d, sda_q, sda_d;
  logic start_c, stop_c, scl_rise, scl_fall;
  st_t  st, nxt, nxt_c;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] mem [DEPTH];
  logic [7:0] bdat [PAGE];
  logic [PAGE-1:0] bval;
  logic swp, perm, pull, ack_c, prot_ok, blocked;
  logic [2:0] pend_op;
  logic [CW-1:0] prog_cnt;

  assign start_c  = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_c   = scl_q & scl_d & ~sda_d & sda_q;
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign busy_o   = prog_cnt != '0;
  assign sda_pull_o = pull;
  assign blocked  = wp_i | (~ptr[ADDR_W-1] & (swp | perm));
  assign prot_ok  = sh[7:4] == PROT_CODE && !sh[0] && !perm &&
                    (sh[3:1] == OP_SET || sh[3:1] == OP_CLR || sh[3:1] == OP_PERM);

  always_comb begin
    ack_c = 1'b0;
    nxt_c = S_IDLE;
    case (st)
      S_CTRL:
        if (!busy_o && sh[7:4] == MEM_CODE) begin
          ack_c = 1'b1;
          nxt_c = sh[0] ? S_RD : S_ADDR;
        end else if (!busy_o && prot_ok) begin
          ack_c = 1'b1;
          nxt_c = S_PROT;
        end
      S_ADDR: begin ack_c = 1'b1; nxt_c = S_WR; end
      S_WR:   begin ack_c = 1'b1; nxt_c = S_WR; end
      S_PROT: nxt_c = S_PROT;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; scl_d <= 1'b1; sda_q <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= scl_i; scl_d <= scl_q; sda_q <= sda_i; sda_d <= sda_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      bval <= '0; swp <= 1'b0; perm <= 1'b0; pull <= 1'b0; pend_op <= '0;
      prog_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) bdat[i] <= '0;
    end else begin
      if (busy_o) prog_cnt <= prog_cnt - 1'b1;
      if (start_c) begin
        st <= S_CTRL; cnt <= '0; pull <= 1'b0; bval <= '0;
      end else if (stop_c) begin
        if (st == S_WR && |bval) begin
          for (int i = 0; i < PAGE; i++)
            if (bval[i] && !blocked) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= bdat[i];
          prog_cnt <= CW'(PROG_CYCLES);
        end
        if (st == S_PROT) begin
          case (pend_op)
            OP_SET:  swp  <= 1'b1;
            OP_CLR:  swp  <= 1'b0;
            default: perm <= 1'b1;
          endcase
          prog_cnt <= CW'(PROG_CYCLES);
        end
        st <= S_IDLE; pull <= 1'b0; bval <= '0;
      end else if (st == S_RD) begin
        if (scl_rise) begin
          if (cnt < 4'd8) cnt <= cnt + 4'd1;
          else if (cnt == 4'd9) begin
            if (sda_q) st <= S_IDLE;
            else begin ptr <= ptr + 1'b1; cnt <= 4'd10; end
          end
        end else if (scl_fall) begin
          if (cnt >= 4'd1 && cnt <= 4'd7) pull <= ~tx[3'(4'd7 - cnt)];
          else if (cnt == 4'd8) begin pull <= 1'b0; cnt <= 4'd9; end
          else if (cnt == 4'd10) begin tx <= mem[ptr]; pull <= ~mem[ptr][7]; cnt <= '0; end
        end
      end else if (st != S_IDLE) begin
        if (scl_rise && cnt < 4'd8) begin
          sh <= {sh[6:0], sda_q}; cnt <= cnt + 4'd1;
        end else if (scl_fall && cnt == 4'd8) begin
          pull <= ack_c; cnt <= 4'd9; nxt <= nxt_c;
          if (ack_c)
            case (st)
              S_CTRL: pend_op <= sh[3:1];
              S_ADDR: ptr <= sh[ADDR_W-1:0];
              S_WR: begin
                bdat[ptr[PAGE_W-1:0]] <= sh;
                bval[ptr[PAGE_W-1:0]] <= 1'b1;
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              end
              default: ;
            endcase
        end else if (scl_fall && cnt == 4'd9) begin
          st <= nxt; cnt <= '0;
          if (nxt == S_RD) begin tx <= mem[ptr]; pull <= ~mem[ptr][7]; end
          else pull <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/twire_eeprom_chk.sv
module twire_eeprom_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic busy_o,
  input logic perm_q
);
  localparam int CW = $clog2(PROG_CYCLES + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else run_len <= '0;

  // R2
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);

  // R3
  prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_len == CW'(PROG_CYCLES));

  // R9
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(perm_q) |-> perm_q);

  // R1
  busy_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> scl_i);
endmodule

bind twire_eeprom twire_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .busy_o(busy_o), .perm_q(perm)
);

// File: tb/twire_eeprom_bench.sv
module twire_eeprom_bench;
  localparam int PROG = 200;
  localparam logic [15:0] VEC [6] = '{16'h053C, 16'h7FA5, 16'h8000,
                                      16'hC35A, 16'hFF81, 16'h41FF};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sdam = 1'b1, wp = 1'b0;
  logic pull, busy;
  wire  sda_line = sdam & ~pull;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #10 clk = ~clk;

  twire_eeprom #(.PROG_CYCLES(PROG)) u_twire_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
    .sda_pull_o(pull), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sdam = 1'b1; tick(4); scl = 1'b1; tick(4); sdam = 1'b0; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sdam = 1'b0; tick(4); scl = 1'b1; tick(4); sdam = 1'b1; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdam = b[i]; tick(4); scl = 1'b1; tick(4); scl = 1'b0;
    end
    sdam = 1'b1; tick(4); scl = 1'b1; tick(2); acked = ~sda_line; tick(2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sdam = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(4); scl = 1'b1; tick(2); b[i] = sda_line; tick(2); scl = 1'b0;
    end
    sdam = ~mack; tick(4); scl = 1'b1; tick(4); scl = 1'b0; sdam = 1'b1;
  endtask

  task automatic wait_idle(output int len);
    len = 0;
    while (busy) begin len++; tick(1); end
  endtask

  task automatic wr(input logic [7:0] a, input int n, input bit eff, input string tag);
    logic ak;
    int   bl;
    bus_start();
    send_byte(8'hA0, ak); chk(ak, "R2 control ack on write", ak, 1);
    send_byte(a, ak);
    for (int k = 0; k < n; k++) send_byte(wbuf[k], ak);
    bus_stop();
    chk(busy == 1'b1, {tag, " R3 busy after stop"}, busy, 1);
    wait_idle(bl);
    chk(bl >= PROG - 4 && bl <= PROG, {tag, " R3 busy length"}, bl, PROG - 2);
    if (eff)
      for (int k = 0; k < n; k++) model[{a[7:4], 4'(a[3:0] + k)}] = wbuf[k];
  endtask

  task automatic rd(input logic [7:0] a, input int n, input string tag);
    logic ak;
    bus_start();
    send_byte(8'hA0, ak);
    send_byte(a, ak);
    bus_start();
    send_byte(8'hA1, ak); chk(ak, {tag, " R2 read control ack"}, ak, 1);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
    chk(pull == 1'b0, {tag, " R5 line released after master nack"}, pull, 0);
    bus_stop();
    for (int k = 0; k < n; k++)
      chk(rbuf[k] == model[8'(a + k)], tag, rbuf[k], model[8'(a + k)]);
  endtask

  task automatic prot(input logic [7:0] code, input bit exp_ack, input string tag);
    logic ak;
    int   bl;
    bus_start();
    send_byte(code, ak);
    chk(ak == exp_ack, tag, ak, exp_ack);
    bus_stop();
    wait_idle(bl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    int   bl;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    tick(5);
    chk(pull == 1'b0, "R11 line released in reset", pull, 0);
    chk(busy == 1'b0, "R11 busy low in reset", busy, 0);
    rst_n = 1'b1;
    tick(5);
    rd(8'h00, 1, "R11 erased memory");

    // R3 R5: vector table of single-byte writes read back
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      wr(VEC[v][15:8], 1, 1'b1, "R3 table write");
      rd(VEC[v][15:8], 1, "R3 table readback");
    end

    // R6: control byte refused while programming
    bus_start(); send_byte(8'hA0, ak); send_byte(8'h44, ak); send_byte(8'h12, ak); bus_stop();
    bus_start(); send_byte(8'hA0, ak);
    chk(ak == 1'b0, "R6 no ack while busy", ak, 0);
    bus_stop();
    wait_idle(bl);
    model[8'h44] = 8'h12;
    rd(8'h44, 1, "R6 earlier write landed");

    // R2: foreign control code
    bus_start(); send_byte(8'h50, ak);
    chk(ak == 1'b0, "R2 foreign code not acked", ak, 0);
    bus_stop();

    // R4: twenty bytes into page 80h starting at 83h
    for (int k = 0; k < 20; k++) wbuf[k] = 8'(8'h20 + k);
    wr(8'h83, 20, 1'b1, "R4 page overflow");
    rd(8'h80, 16, "R4 last sixteen kept");

    // R5: sequential read wraps FFh to 00h
    rd(8'hFE, 3, "R5 sequential wrap");

    // R1: repeated start discards buffered data
    bus_start(); send_byte(8'hA0, ak); send_byte(8'hB0, ak); send_byte(8'h11, ak);
    bus_start(); send_byte(8'hA0, ak); send_byte(8'hB1, ak); send_byte(8'h22, ak);
    bus_stop();
    wait_idle(bl);
    model[8'hB1] = 8'h22;
    rd(8'hB0, 2, "R1 restart discards data");

    // R7
    prot(8'h62, 1'b1, "R7 set command acked");
    wbuf[0] = 8'h55; wr(8'h10, 1, 1'b0, "R7 lower write");
    wbuf[0] = 8'h66; wr(8'h90, 1, 1'b1, "R7 upper write");
    rd(8'h10, 1, "R7 lower half blocked");
    rd(8'h90, 1, "R7 upper half writable");

    // R8
    prot(8'h66, 1'b1, "R8 clear command acked");
    wbuf[0] = 8'h77; wr(8'h10, 1, 1'b1, "R8 lower write");
    rd(8'h10, 1, "R8 lower half writable again");

    // R10
    wp = 1'b1;
    wbuf[0] = 8'h99; wr(8'hA0, 1, 1'b0, "R10 pin write");
    wp = 1'b0;
    rd(8'hA0, 1, "R10 pin blocks array");

    // R9
    prot(8'h60, 1'b1, "R9 permanent command acked");
    wbuf[0] = 8'h33; wr(8'h20, 1, 1'b0, "R9 lower write");
    prot(8'h66, 1'b0, "R9 clear refused without ack");
    wbuf[0] = 8'h34; wr(8'h20, 1, 1'b0, "R9 lower write after clear");
    rd(8'h20, 1, "R9 lower half still blocked");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule